// File: doc/BRIEF.md
# Exception Entry Controller

This block sits at the exception boundary of a processor pipeline. Each cycle it samples a vector of pending exception requests and picks one by fixed priority. For the chosen exception it works out the full entry state. That state covers the new status word, with its mode field, mask bits, endianness bit and instruction-state bits. It also covers the return link, the status word to be saved and the address of the vector fetch. The current mode is the low five bits of the incoming status word.

All results are registered and appear one cycle after the requests are sampled. They come with a one-cycle entry strobe and the index of the chosen exception. The interface is plain control, with no valid/ready handshake. The strobe is a single-cycle pulse that the pipeline must take when it appears, and there is no back-pressure. A secure monitor call is the one exception whose entry depends on privilege. From user mode it is taken as an undefined instruction. From any other mode it enters monitor mode at a fixed offset from the monitor base.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Request bit k means exception k, and entry_idx reports the chosen k. Priority falls as k rises: 0 reset, 1 precise data abort, 2 FIQ, 3 IRQ, 4 prefetch abort, 5 imprecise data abort, 6 breakpoint, 7 undefined instruction, 8 supervisor call, 9 secure monitor call.
- R2: Bits 6 to 9 form the decoded-instruction group, which should never arrive together. If several of them are set anyway, the lowest index wins.
- R3: When any request bit is set at a clock edge, entry_valid is high for the following cycle, and entry_idx and the other results belong to that same cycle.
- R4: When no request is set at an edge, entry_valid and entry_idx are low in the next cycle, status_out equals the status word sampled at that edge, and link_out, saved_out and vector_out are zero.
- R5: A secure monitor call made from a mode other than user (status bits [4:0] not equal to 0b10000) sets the mode field to 0b10110 and sets bits 6, 7 and 8. vector_out is then mon_base + 0x08, whatever hivec_sel is.
- R6: A secure monitor call made from user mode sets the mode field to 0b11011 and sets bit 7, and keeps bits 6 and 8 as they were. It uses the undefined-instruction vector offset 0x04 and the base selection rule of R9.
- R7: On every entry, bits 5 and 24 of status_out are cleared and bit 9 takes sec_ee. Bits other than [9:0] and 24 are copied from the old status word. Mask bits 6, 7 and 8 are only ever set or kept, never cleared.
- R8: On every entry, link_out equals next_pc and saved_out equals the old status word.
- R9: For every exception except the non-user secure monitor call, vector_out is the base plus the offset for that exception. The base is 0xFFFF0000 when hivec_sel is 1 and sec_base when it is 0. The default offsets are: reset 0x00, undefined 0x04, supervisor call 0x08, prefetch abort and breakpoint 0x0C, both data aborts 0x10, IRQ 0x18, FIQ 0x1C.
- R10: The entry modes and masks set (F = bit 6, I = bit 7, A = bit 8) are:
  - reset: mode 0b10011, sets F, I and A.
  - FIQ: mode 0b10001, sets F, I and A.
  - IRQ: mode 0b10010, sets I and A.
  - both data aborts, prefetch abort and breakpoint: mode 0b10111, sets I and A.
  - undefined instruction and supervisor call: modes 0b11011 and 0b10011, set I only.
- R11: While rst_n is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 10 | Pending exception requests, bit index as in R1 |
| status_in | input | 32 | Current status word; bits [4:0] are the current mode |
| next_pc | input | ADDR_W | Address of the instruction after the one taking the exception |
| hivec_sel | input | 1 | Selects the high vector base |
| sec_ee | input | 1 | Secure endianness control bit, copied to status bit 9 |
| sec_base | input | ADDR_W | Low vector base address |
| mon_base | input | ADDR_W | Monitor vector base address |
| entry_valid | output | 1 | One-cycle entry strobe |
| entry_idx | output | 4 | Index of the exception taken |
| status_out | output | 32 | New status word, or the pass-through status when idle |
| link_out | output | ADDR_W | Return link for the target mode |
| saved_out | output | 32 | Status word to save in the target mode |
| vector_out | output | ADDR_W | Vector fetch address |

## Verification
The bench goes after the secure monitor call from both sides of the user-mode boundary. It does so with the F and A bits preset both to zero and to one, so a design that ignored privilege, or that cleared the masks it should keep, shows a wrong mode, wrong mask bits or a vector on the wrong base. It sends requests for the whole vector at once and for overlapping subsets of the decoded-instruction group. An inverted or broken priority chain then reports the wrong index. It also toggles hivec_sel under a non-user monitor call, which must not move that vector. Idle cycles check that the status word passes through, so a design that held stale entry results would be caught.

// File: rtl/exc_entry_pkg.sv
`timescale 1ns/1ps
package exc_entry_pkg;
  localparam int NUM_EXC = 10;
  localparam int IDX_W   = $clog2(NUM_EXC);

  typedef enum logic [IDX_W-1:0] {
    EXC_RESET  = 4'd0,
    EXC_DABT   = 4'd1,
    EXC_FIQ    = 4'd2,
    EXC_IRQ    = 4'd3,
    EXC_PABT   = 4'd4,
    EXC_IMPABT = 4'd5,
    EXC_BKPT   = 4'd6,
    EXC_UNDEF  = 4'd7,
    EXC_SVC    = 4'd8,
    EXC_SMC    = 4'd9
  } exc_e;

  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_MON = 5'b10110;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;

  localparam int BIT_T = 5;
  localparam int BIT_F = 6;
  localparam int BIT_I = 7;
  localparam int BIT_A = 8;
  localparam int BIT_E = 9;
  localparam int BIT_J = 24;

  typedef struct packed {
    logic [4:0] mode;
    logic       set_f;
    logic       set_i;
    logic       set_a;
  } entry_cfg_t;
endpackage

// File: rtl/exc_prio_pick.sv
`timescale 1ns/1ps
module exc_prio_pick
  import exc_entry_pkg::*;
#(
  parameter int N  = NUM_EXC,
  parameter int IW = IDX_W
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [N-1:0] higher;
  logic [N-1:0] grant;

  // prefix OR: higher[i] is set when a more urgent request is pending
  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_chain
      if (gi == 0) begin : g_first
        assign higher[gi] = 1'b0;
      end else begin : g_rest
        assign higher[gi] = higher[gi-1] | req[gi-1];
      end
      assign grant[gi] = req[gi] & ~higher[gi];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = idx | IW'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/exc_entry_calc.sv
`timescale 1ns/1ps
module exc_entry_calc
  import exc_entry_pkg::*;
#(
  parameter int                        ADDR_W        = 32,
  parameter logic [ADDR_W-1:0]         HIGH_BASE     = 32'hFFFF0000,
  parameter logic [NUM_EXC*8-1:0]      VEC_OFF_TABLE = {8'h08, 8'h08, 8'h04, 8'h0C, 8'h10,
                                                        8'h0C, 8'h18, 8'h1C, 8'h10, 8'h00},
  parameter int                        MON_OFF       = 8
) (
  input  exc_e              kind,
  input  logic [31:0]       status_in,
  input  logic              hivec_sel,
  input  logic              sec_ee,
  input  logic [ADDR_W-1:0] sec_base,
  input  logic [ADDR_W-1:0] mon_base,
  output logic [31:0]       status_new,
  output logic [ADDR_W-1:0] vector
);
  logic              from_user;
  logic              to_monitor;
  entry_cfg_t        cfg;
  exc_e              off_kind;
  logic [7:0]        off;
  logic [ADDR_W-1:0] base;

  always_comb begin
    from_user  = (status_in[4:0] == MODE_USR);
    to_monitor = (kind == EXC_SMC) && !from_user;

    unique case (kind)
      EXC_RESET:  cfg = '{mode: MODE_SVC, set_f: 1'b1, set_i: 1'b1, set_a: 1'b1};
      EXC_FIQ:    cfg = '{mode: MODE_FIQ, set_f: 1'b1, set_i: 1'b1, set_a: 1'b1};
      EXC_IRQ:    cfg = '{mode: MODE_IRQ, set_f: 1'b0, set_i: 1'b1, set_a: 1'b1};
      EXC_DABT,
      EXC_PABT,
      EXC_IMPABT,
      EXC_BKPT:   cfg = '{mode: MODE_ABT, set_f: 1'b0, set_i: 1'b1, set_a: 1'b1};
      EXC_UNDEF:  cfg = '{mode: MODE_UND, set_f: 1'b0, set_i: 1'b1, set_a: 1'b0};
      EXC_SVC:    cfg = '{mode: MODE_SVC, set_f: 1'b0, set_i: 1'b1, set_a: 1'b0};
      EXC_SMC:    cfg = from_user ? '{mode: MODE_UND, set_f: 1'b0, set_i: 1'b1, set_a: 1'b0}
                                  : '{mode: MODE_MON, set_f: 1'b1, set_i: 1'b1, set_a: 1'b1};
      default:    cfg = '{mode: MODE_UND, set_f: 1'b0, set_i: 1'b1, set_a: 1'b0};
    endcase

    // a call from user mode borrows the undefined-instruction slot
    off_kind = (kind == EXC_SMC) ? EXC_UNDEF : kind;
    off      = VEC_OFF_TABLE[int'(off_kind)*8 +: 8];
    base     = hivec_sel ? HIGH_BASE : sec_base;
    vector   = to_monitor ? (mon_base + ADDR_W'(MON_OFF)) : (base + ADDR_W'(off));

    status_new        = status_in;
    status_new[4:0]   = cfg.mode;
    status_new[BIT_T] = 1'b0;
    status_new[BIT_F] = status_in[BIT_F] | cfg.set_f;
    status_new[BIT_I] = status_in[BIT_I] | cfg.set_i;
    status_new[BIT_A] = status_in[BIT_A] | cfg.set_a;
    status_new[BIT_E] = sec_ee;
    status_new[BIT_J] = 1'b0;
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
`timescale 1ns/1ps
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int                   ADDR_W        = 32,
  parameter logic [ADDR_W-1:0]    HIGH_BASE     = 32'hFFFF0000,
  parameter logic [NUM_EXC*8-1:0] VEC_OFF_TABLE = {8'h08, 8'h08, 8'h04, 8'h0C, 8'h10,
                                                   8'h0C, 8'h18, 8'h1C, 8'h10, 8'h00},
  parameter int                   MON_OFF       = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXC-1:0] exc_req,
  input  logic [31:0]        status_in,
  input  logic [ADDR_W-1:0]  next_pc,
  input  logic               hivec_sel,
  input  logic               sec_ee,
  input  logic [ADDR_W-1:0]  sec_base,
  input  logic [ADDR_W-1:0]  mon_base,
  output logic               entry_valid,
  output logic [IDX_W-1:0]   entry_idx,
  output logic [31:0]        status_out,
  output logic [ADDR_W-1:0]  link_out,
  output logic [31:0]        saved_out,
  output logic [ADDR_W-1:0]  vector_out
);
  logic              pend;
  logic [IDX_W-1:0]  pick;
  logic [31:0]       st_new;
  logic [ADDR_W-1:0] vec_new;

  exc_prio_pick #(.N(NUM_EXC), .IW(IDX_W)) u_pick (
    .req (exc_req),
    .any (pend),
    .idx (pick)
  );

  exc_entry_calc #(
    .ADDR_W        (ADDR_W),
    .HIGH_BASE     (HIGH_BASE),
    .VEC_OFF_TABLE (VEC_OFF_TABLE),
    .MON_OFF       (MON_OFF)
  ) u_calc (
    .kind       (exc_e'(pick)),
    .status_in  (status_in),
    .hivec_sel  (hivec_sel),
    .sec_ee     (sec_ee),
    .sec_base   (sec_base),
    .mon_base   (mon_base),
    .status_new (st_new),
    .vector     (vec_new)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_valid <= 1'b0;
      entry_idx   <= '0;
      status_out  <= '0;
      link_out    <= '0;
      saved_out   <= '0;
      vector_out  <= '0;
    end else if (pend) begin
      entry_valid <= 1'b1;
      entry_idx   <= pick;
      status_out  <= st_new;
      link_out    <= next_pc;
      saved_out   <= status_in;
      vector_out  <= vec_new;
    end else begin
      entry_valid <= 1'b0;
      entry_idx   <= '0;
      status_out  <= status_in;
      link_out    <= '0;
      saved_out   <= '0;
      vector_out  <= '0;
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
`timescale 1ns/1ps
module exc_entry_chk
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int MON_OFF = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_EXC-1:0] exc_req,
  input logic [31:0]        status_in,
  input logic [ADDR_W-1:0]  next_pc,
  input logic               sec_ee,
  input logic [ADDR_W-1:0]  mon_base,
  input logic               entry_valid,
  input logic [IDX_W-1:0]   entry_idx,
  input logic [31:0]        status_out,
  input logic [ADDR_W-1:0]  link_out,
  input logic [31:0]        saved_out,
  input logic [ADDR_W-1:0]  vector_out
);
  logic               warm;
  logic [NUM_EXC-1:0] req_q;
  logic [31:0]        st_q;
  logic [ADDR_W-1:0]  pc_q;
  logic [ADDR_W-1:0]  mb_q;
  logic               ee_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm  <= 1'b0;
      req_q <= '0;
      st_q  <= '0;
      pc_q  <= '0;
      mb_q  <= '0;
      ee_q  <= 1'b0;
    end else begin
      warm  <= 1'b1;
      req_q <= exc_req;
      st_q  <= status_in;
      pc_q  <= next_pc;
      mb_q  <= mon_base;
      ee_q  <= sec_ee;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !entry_valid); // R11

  AST_PRIO_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    warm && entry_valid |-> req_q[entry_idx] &&
      ((req_q & ((NUM_EXC'(1) << entry_idx) - NUM_EXC'(1))) == '0)); // R1

  AST_STROBE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (entry_valid == (|req_q))); // R3

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    warm && !entry_valid |-> status_out == st_q && vector_out == '0); // R4

  AST_MON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    warm && entry_valid && entry_idx == EXC_SMC && st_q[4:0] != MODE_USR |->
      status_out[4:0] == MODE_MON && status_out[8:6] == 3'b111 &&
      vector_out == mb_q + ADDR_W'(MON_OFF)); // R5

  AST_USER_CALL: assert property (@(posedge clk) disable iff (!rst_n)
    warm && entry_valid && entry_idx == EXC_SMC && st_q[4:0] == MODE_USR |->
      status_out[4:0] == MODE_UND && status_out[7] &&
      status_out[6] == st_q[6] && status_out[8] == st_q[8]); // R6

  AST_ENTRY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    warm && entry_valid |-> !status_out[5] && !status_out[24] &&
      status_out[9] == ee_q && status_out[31:25] == st_q[31:25]); // R7

  AST_LINK_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    warm && entry_valid |-> link_out == pc_q && saved_out == st_q); // R8
endmodule

bind exc_entry_ctrl exc_entry_chk #(.ADDR_W(ADDR_W), .MON_OFF(MON_OFF)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .exc_req     (exc_req),
  .status_in   (status_in),
  .next_pc     (next_pc),
  .sec_ee      (sec_ee),
  .mon_base    (mon_base),
  .entry_valid (entry_valid),
  .entry_idx   (entry_idx),
  .status_out  (status_out),
  .link_out    (link_out),
  .saved_out   (saved_out),
  .vector_out  (vector_out)
);

// File: tb/exc_entry_ctrl_tb.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  exc_req = '0;
  logic [31:0] status_in = '0;
  logic [31:0] next_pc = '0;
  logic        hivec_sel = 1'b0;
  logic        sec_ee = 1'b0;
  logic [31:0] sec_base = '0;
  logic [31:0] mon_base = '0;
  logic        entry_valid;
  logic [3:0]  entry_idx;
  logic [31:0] status_out;
  logic [31:0] link_out;
  logic [31:0] saved_out;
  logic [31:0] vector_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic        e_valid;
  logic [3:0]  e_idx;
  logic [31:0] e_st, e_link, e_saved, e_vec;
  string       st_tag, vec_tag;

  always #4 clk = ~clk;

  exc_entry_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .status_in(status_in),
    .next_pc(next_pc), .hivec_sel(hivec_sel), .sec_ee(sec_ee),
    .sec_base(sec_base), .mon_base(mon_base), .entry_valid(entry_valid),
    .entry_idx(entry_idx), .status_out(status_out), .link_out(link_out),
    .saved_out(saved_out), .vector_out(vector_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] vec_off(input int k);
    case (k)
      0: return 8'h00;
      1, 5: return 8'h10;
      2: return 8'h1C;
      3: return 8'h18;
      4, 6: return 8'h0C;
      7: return 8'h04;
      default: return 8'h08;
    endcase
  endfunction

  // expected values from the requirements
  task automatic model();
    bit user, f, i, a, found;
    logic [4:0] md;
    logic [7:0] off;
    found = 0; e_idx = 0;
    for (int k = 0; k < 10; k++) if (exc_req[k] && !found) begin e_idx = 4'(k); found = 1; end
    e_valid = |exc_req;
    user = (status_in[4:0] == 5'b10000);
    if (!e_valid) begin
      e_st = status_in; e_link = 0; e_saved = 0; e_vec = 0; st_tag = "R4"; vec_tag = "R4";
      return;
    end
    off = vec_off(int'(e_idx)); f = 0; a = 0; i = 1; st_tag = "R10"; vec_tag = "R9";
    case (e_idx)
      0: begin md = 5'b10011; f = 1; a = 1; end
      2: begin md = 5'b10001; f = 1; a = 1; end
      3: begin md = 5'b10010; a = 1; end
      1, 4, 5, 6: begin md = 5'b10111; a = 1; end
      7: md = 5'b11011;
      8: md = 5'b10011;
      default: begin
        if (user) begin md = 5'b11011; off = 8'h04; st_tag = "R6"; vec_tag = "R6"; end
        else begin md = 5'b10110; f = 1; a = 1; st_tag = "R5"; vec_tag = "R5"; end
      end
    endcase
    e_st = status_in;
    e_st[4:0] = md; e_st[5] = 0; e_st[24] = 0; e_st[9] = sec_ee;
    if (f) e_st[6] = 1;
    if (i) e_st[7] = 1;
    if (a) e_st[8] = 1;
    e_link = next_pc; e_saved = status_in;
    if (e_idx == 9 && !user) e_vec = mon_base + 32'h8;
    else e_vec = (hivec_sel ? 32'hFFFF0000 : sec_base) + 32'(off);
  endtask

  task automatic compare();
    chk(entry_valid == e_valid, "R3 strobe", 32'(entry_valid), 32'(e_valid));
    chk(entry_idx == e_idx, "R1/R2 index", 32'(entry_idx), 32'(e_idx));
    chk(status_out == e_st, {st_tag, " status"}, status_out, e_st);
    chk(vector_out == e_vec, {vec_tag, " vector"}, vector_out, e_vec);
    chk(link_out == e_link && saved_out == e_saved, "R8 link/saved", link_out ^ saved_out, e_link ^ e_saved);
    if (e_valid)
      chk(!status_out[5] && !status_out[24] && status_out[9] == sec_ee_q, "R7 fixed bits",
          {22'd0, status_out[24], status_out[9], status_out[5], 7'd0}, {23'd0, sec_ee_q, 8'd0});
  endtask

  logic sec_ee_q;

  task automatic drive(input logic [9:0] rq, input logic [31:0] st, input logic hv, input logic ee);
    exc_req = rq; status_in = st; hivec_sel = hv; sec_ee = ee;
    next_pc = $urandom; sec_base = $urandom & 32'hFFFF_FF00; mon_base = $urandom & 32'hFFFF_FF00;
    model();
    sec_ee_q = ee;
    @(negedge clk);
    compare();
  endtask

  function automatic logic [31:0] rand_status(input bit want_user);
    logic [31:0] s;
    logic [4:0] modes [7] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10110, 5'b10111, 5'b11011};
    s = $urandom;
    s[4:0] = want_user ? 5'b10000 : modes[1 + ($urandom % 6)];
    return s;
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D2C_3B4A));
    exc_req = 10'h3FF; status_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    // R11: outputs held at zero in reset despite active inputs
    chk(!entry_valid && entry_idx == 0 && status_out == 0 && vector_out == 0 &&
        link_out == 0 && saved_out == 0, "R11 reset state", status_out | vector_out, 32'h0);
    exc_req = 0;
    @(negedge clk);
    rst_n = 1'b1;

    // directed corners
    drive(10'h000, rand_status(0), 0, 0);                       // R4 idle
    drive(10'h3FF, rand_status(0), 1, 1);                       // R1 all pending, reset wins
    drive(10'h3C0, rand_status(1), 0, 0);                       // R2 group overlap, bkpt
    drive(10'h380, rand_status(0), 1, 1);                       // R2 undef over svc/smc
    drive(10'h300, rand_status(0), 0, 1);                       // R2 svc over smc
    drive(10'h200, rand_status(0) & ~32'h1C0, 1, 1);            // R5 masks were clear, hivec ignored
    drive(10'h200, rand_status(0) | 32'h1C0, 0, 0);             // R5
    drive(10'h200, rand_status(1) & ~32'h1C0, 1, 1);            // R6 F/A stay 0
    drive(10'h200, rand_status(1) | 32'h140, 0, 0);             // R6 F/A stay 1
    drive(10'h200, rand_status(1) & ~32'h1C0, 0, 1);            // R6 low base
    for (int k = 0; k < 10; k++) begin
      drive(10'(1 << k), rand_status(0), 1'(k & 1), 1'(k >> 1)); // R9 R10 each kind
      drive(10'h000, rand_status(k[0]), 0, 1);                   // R4 between
    end

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      logic [9:0] rq;
      case ($urandom % 4)
        0: rq = 10'h000;
        1: rq = 10'(1 << ($urandom % 10));
        2: rq = 10'($urandom % 16) << 6;
        default: rq = 10'($urandom);
      endcase
      drive(rq, rand_status(($urandom % 2) == 0), 1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule